// File: doc/BRIEF.md
# Periodic Interval Timer with Optional Millisecond Base

The block is a periodic interval timer on a byte-wide register bus. Software writes an 8-bit interval value N. The block then counts base ticks and raises a one-clock interrupt pulse each time N+1 base ticks have passed. After each expiry it reloads from the stored interval and keeps running. The base tick is normally an incoming one-microsecond strobe. A build-time parameter can place a divide-by-1000 prescaler in front of the counter, so the same 8-bit value gives periods of 1 to 256 ms instead of 1 to 256 µs.

Any accepted write to the interval register restarts the period at once. The running count and the prescaler phase are both reloaded or cleared, so an interrupt from the old interval cannot arrive late. A second build-time parameter makes interval writes privileged: when it is set, a write is taken only while the `priv` input is high.

The control is a three-state machine:
- **IDLE** is the state after reset. The counter does not run and no interrupt is raised.
- **IDLE → COUNT** happens on the first accepted write.
- **COUNT → COUNT** happens on every base tick with a nonzero count (the count decrements), on every cycle without a tick, and on every accepted write (the count reloads).
- **COUNT → FIRE** happens on a base tick while the count is zero. The count reloads from the interval.
- **FIRE** lasts one clock and drives the interrupt. It leaves by the same rules as COUNT: to COUNT, or to FIRE again if another expiring tick arrives at once.

Top module: `tick_interval_timer`

## Requirements
- R1: After synchronous reset the interval reads 0, `irq` is low, and the timer stays idle with no interrupt whatever ticks arrive, until the first accepted interval write.
- R2: After an accepted write of value N, `irq` first rises in the clock after the (N+1)-th base tick that follows the write. N=0 gives 1 tick and N=255 gives 256 ticks.
- R3: After each expiry the count reloads from the stored interval, and every later period is again N+1 base ticks.
- R4: `irq` is high for exactly one clock per expiry.
- R5: An accepted write restarts the count from the new value immediately. No interrupt results from the interval that was replaced.
- R6: Reads are registered. One clock after `bus_rd` with `bus_addr` = 0, `bus_rdata` holds the last accepted interval. A read at any other address returns 0.
- R7: With WPROT=1, an interval write while `priv` is low has no effect: the stored value is unchanged and the count is not restarted. A write while `priv` is high is accepted.
- R8: With WPROT=0, interval writes are accepted whatever the level of `priv`.
- R9: With MS_MODE=1, one base tick occurs every 1000 microsecond ticks, so interval N expires after (N+1)·1000 microsecond ticks.
- R10: With MS_MODE=1, an accepted write also clears the prescaler. The first expiry after the write therefore takes a full (N+1)·1000 microsecond ticks, whatever phase the prescaler had reached.
- R11: Writes to any address other than 0 leave the interval and the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| usec_tick | input | 1 | One-clock strobe, once per microsecond |
| priv | input | 1 | Privilege level; gates interval writes when WPROT=1 |
| bus_addr | input | AW | Register address; the interval register is at address 0 |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DW | Registered read data |
| irq | output | 1 | One-clock interrupt pulse on each expiry |

## Verification
The main function is measured by counting ticks from a write to the first interrupt, for three interval values:
- 0 separates off-by-one errors from correct reload handling.
- 3 shows ordinary decrementing.
- 255 shows that the full count range is reached without wrap.

A second period after the same write separates a correct reload from a reload to zero or to a stale value.

Rewriting the interval in the middle of a period separates an immediate restart from a restart that waits for the old expiry. A write refused by the privilege check, made in the middle of a period, must leave the remaining tick count unchanged.

On the millisecond build, a write made partway through a prescaler cycle separates a prescaler that clears from one that keeps its phase, since the two give 1000 and 500 ticks.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_FIRE  = 2'd2
    } itmr_state_e;

endpackage

// File: rtl/itmr_prescale.sv
module itmr_prescale #(
    parameter int PRESCALE = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic usec_tick,
    input  logic clr,
    output logic base_tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] pre_q;
    logic          at_last;

    assign at_last   = (pre_q == LAST);
    assign base_tick = usec_tick && at_last && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q <= '0;
        end else if (usec_tick) begin
            pre_q <= at_last ? '0 : pre_q + 1'b1;
        end
    end

    // R9: phase counter never leaves its range
    a_r9_pre_bound: assert property (@(posedge clk) disable iff (rst)
        pre_q <= LAST);

    // R10: a write clears the phase
    a_r10_clear_phase: assert property (@(posedge clk) disable iff (rst)
        clr |=> (pre_q == '0));

endmodule

// File: rtl/itmr_core.sv
module itmr_core
    import itmr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic [DW-1:0] reload_val,
    input  logic          base_tick,
    output logic          irq_o
);
    itmr_state_e   state_q, state_d;
    logic [DW-1:0] cnt_q, cnt_d;

    // state and count register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load) begin
                    state_d = ST_COUNT;
                    cnt_d   = load_val;
                end
            end
            ST_COUNT, ST_FIRE: begin
                if (load) begin
                    state_d = ST_COUNT;
                    cnt_d   = load_val;
                end else if (base_tick && (cnt_q == '0)) begin
                    state_d = ST_FIRE;
                    cnt_d   = reload_val;
                end else if (base_tick) begin
                    state_d = ST_COUNT;
                    cnt_d   = cnt_q - 1'b1;
                end else begin
                    state_d = ST_COUNT;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        irq_o = (state_q == ST_FIRE);
    end

    // R4: pulse ends unless another expiring tick follows at once
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !base_tick) |=> !irq_o);

    // R5: write reloads immediately and suppresses the old expiry
    a_r5_write_restart: assert property (@(posedge clk) disable iff (rst)
        load |=> ((cnt_q == $past(load_val)) && !irq_o));

    // R2: expiring tick yields the interrupt next clock
    a_r2_expire: assert property (@(posedge clk) disable iff (rst)
        ((state_q != ST_IDLE) && !load && base_tick && (cnt_q == '0)) |=> irq_o);

    // R3: on each interrupt the count holds the stored interval
    a_r3_reloaded: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (cnt_q == reload_val));

endmodule

// File: rtl/tick_interval_timer.sv
module tick_interval_timer #(
    parameter bit MS_MODE  = 1'b1,
    parameter bit WPROT    = 1'b1,
    parameter int PRESCALE = 1000,
    parameter int AW       = 2,
    parameter int DW       = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          usec_tick,
    input  logic          priv,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    localparam logic [AW-1:0] IVL_ADDR = '0;

    logic          hit;
    logic          wr_ok;
    logic          base_tick;
    logic [DW-1:0] ivl_q;

    assign hit   = (bus_addr == IVL_ADDR);
    assign wr_ok = bus_wr && hit && (!WPROT || priv);

    always_ff @(posedge clk) begin
        if (rst) begin
            ivl_q     <= '0;
            bus_rdata <= '0;
        end else begin
            if (wr_ok) ivl_q <= bus_wdata;
            bus_rdata <= (bus_rd && hit) ? ivl_q : '0;
        end
    end

    generate
        if (MS_MODE) begin : g_ms
            itmr_prescale #(.PRESCALE(PRESCALE)) u_pre (
                .clk       (clk),
                .rst       (rst),
                .usec_tick (usec_tick),
                .clr       (wr_ok),
                .base_tick (base_tick)
            );
        end else begin : g_us
            assign base_tick = usec_tick;
        end
    endgenerate

    itmr_core #(.DW(DW)) u_core (
        .clk        (clk),
        .rst        (rst),
        .load       (wr_ok),
        .load_val   (bus_wdata),
        .reload_val (ivl_q),
        .base_tick  (base_tick),
        .irq_o      (irq)
    );

    // R7: unprivileged write leaves the interval alone
    a_r7_locked: assert property (@(posedge clk) disable iff (rst)
        ((WPROT != 1'b0) && bus_wr && hit && !priv) |=> $stable(ivl_q));

    // R11: writes elsewhere leave the interval alone
    a_r11_miss: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !hit) |=> $stable(ivl_q));

    // R6: registered readback of the interval
    a_r6_readback: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && hit) |=> (bus_rdata == $past(ivl_q)));

endmodule

// File: tb/tick_interval_timer_tb.sv
module tick_interval_timer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_a = 1'b0, tick_b = 1'b0;
    logic       priv = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_a = 1'b0, wr_b = 1'b0, rd_a = 1'b0, rd_b = 1'b0;
    logic [7:0] rdata_a, rdata_b;
    logic       irq_a, irq_b;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    tick_interval_timer #(.MS_MODE(1'b0), .WPROT(1'b1)) u_dut (
        .clk(clk), .rst(rst), .usec_tick(tick_a), .priv(priv),
        .bus_addr(addr), .bus_wr(wr_a), .bus_wdata(wdata), .bus_rd(rd_a),
        .bus_rdata(rdata_a), .irq(irq_a)
    );

    tick_interval_timer #(.MS_MODE(1'b1), .WPROT(1'b0)) u_dut_ms (
        .clk(clk), .rst(rst), .usec_tick(tick_b), .priv(priv),
        .bus_addr(addr), .bus_wr(wr_b), .bus_wdata(wdata), .bus_rd(rd_b),
        .bus_rdata(rdata_b), .irq(irq_b)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input bit sel, input logic [1:0] a, input logic [7:0] d, input bit p);
        addr = a; wdata = d; priv = p;
        if (sel) wr_b = 1'b1; else wr_a = 1'b1;
        @(negedge clk);
        wr_a = 1'b0; wr_b = 1'b0; priv = 1'b0;
    endtask

    task automatic bus_read(input bit sel, input logic [1:0] a, output logic [7:0] v);
        addr = a;
        if (sel) rd_b = 1'b1; else rd_a = 1'b1;
        @(negedge clk);
        rd_a = 1'b0; rd_b = 1'b0;
        v = sel ? rdata_b : rdata_a;
    endtask

    task automatic pulse(input bit sel, output bit fired);
        if (sel) tick_b = 1'b1; else tick_a = 1'b1;
        @(negedge clk);
        tick_a = 1'b0; tick_b = 1'b0;
        fired = sel ? irq_b : irq_a;
    endtask

    // ticks until the first interrupt, 0 if none within limit
    task automatic ticks_to_fire(input bit sel, input int limit, output int n);
        bit f;
        n = 0;
        for (int i = 1; i <= limit; i++) begin
            pulse(sel, f);
            if (f) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic t_reset;
        logic [7:0] v;
        int n;
        check(irq_a == 1'b0, "R1 irq after reset", irq_a, 0);
        bus_read(1'b0, 2'd0, v);
        check(v == 8'd0, "R1 interval after reset", v, 0);
        ticks_to_fire(1'b0, 5, n);
        check(n == 0, "R1 idle ignores ticks", n, 0);
    endtask

    task automatic t_protect;
        logic [7:0] v;
        int n;
        bus_write(1'b0, 2'd0, 8'd3, 1'b0);
        bus_read(1'b0, 2'd0, v);
        check(v == 8'd0, "R7 unprivileged write refused", v, 0);
        ticks_to_fire(1'b0, 5, n);
        check(n == 0, "R7 refused write does not start timer", n, 0);
        bus_write(1'b0, 2'd0, 8'd3, 1'b1);
        bus_read(1'b0, 2'd0, v);
        check(v == 8'd3, "R7 R6 privileged write readback", v, 3);
    endtask

    task automatic t_period;
        int n;
        ticks_to_fire(1'b0, 20, n);
        check(n == 4, "R2 interval 3 first period", n, 4);
        @(negedge clk);
        check(irq_a == 1'b0, "R4 pulse lasts one clock", irq_a, 0);
        ticks_to_fire(1'b0, 20, n);
        check(n == 4, "R3 interval 3 second period", n, 4);
    endtask

    task automatic t_edges;
        int n;
        bus_write(1'b0, 2'd0, 8'd0, 1'b1);
        ticks_to_fire(1'b0, 5, n);
        check(n == 1, "R2 interval 0", n, 1);
        @(negedge clk);
        ticks_to_fire(1'b0, 5, n);
        check(n == 1, "R3 interval 0 repeat", n, 1);
        bus_write(1'b0, 2'd0, 8'd255, 1'b1);
        ticks_to_fire(1'b0, 300, n);
        check(n == 256, "R2 interval 255", n, 256);
    endtask

    task automatic t_restart;
        int n;
        bus_write(1'b0, 2'd0, 8'd10, 1'b1);
        ticks_to_fire(1'b0, 6, n);
        check(n == 0, "R5 no early expiry", n, 0);
        bus_write(1'b0, 2'd0, 8'd2, 1'b1);
        ticks_to_fire(1'b0, 20, n);
        check(n == 3, "R5 restart with new interval", n, 3);
    endtask

    task automatic t_locked_midway;
        logic [7:0] v;
        int n;
        bus_write(1'b0, 2'd0, 8'd5, 1'b1);
        ticks_to_fire(1'b0, 3, n);
        check(n == 0, "R7 no expiry yet", n, 0);
        bus_write(1'b0, 2'd0, 8'd1, 1'b0);
        ticks_to_fire(1'b0, 20, n);
        check(n == 3, "R7 refused write keeps count", n, 3);
        bus_read(1'b0, 2'd0, v);
        check(v == 8'd5, "R7 interval unchanged", v, 5);
    endtask

    task automatic t_other_addr;
        logic [7:0] v;
        int n;
        bus_write(1'b0, 2'd0, 8'd2, 1'b1);
        ticks_to_fire(1'b0, 1, n);
        bus_write(1'b0, 2'd1, 8'd9, 1'b1);
        bus_read(1'b0, 2'd0, v);
        check(v == 8'd2, "R11 other address ignored", v, 2);
        ticks_to_fire(1'b0, 10, n);
        check(n == 2, "R11 count not restarted", n, 2);
        bus_read(1'b0, 2'd1, v);
        check(v == 8'd0, "R6 other address reads zero", v, 0);
    endtask

    task automatic t_millisecond;
        logic [7:0] v;
        int n;
        bus_write(1'b1, 2'd0, 8'd1, 1'b0);
        bus_read(1'b1, 2'd0, v);
        check(v == 8'd1, "R8 write without privilege accepted", v, 1);
        ticks_to_fire(1'b1, 3000, n);
        check(n == 2000, "R9 interval 1 in ms mode", n, 2000);
        ticks_to_fire(1'b1, 1500, n);
        check(n == 0, "R9 no expiry mid period", n, 0);
        bus_write(1'b1, 2'd0, 8'd0, 1'b0);
        ticks_to_fire(1'b1, 3000, n);
        check(n == 1000, "R10 prescaler cleared on write", n, 1000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_protect();
        t_period();
        t_edges();
        t_restart();
        t_locked_midway();
        t_other_addr();
        t_millisecond();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule